// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block takes the 32-bit word that a CPU writes to the software-interrupt register and turns it into pending-set strobes for a group of destination CPUs. The word carries a software interrupt number, an explicit list of CPUs and a two-bit filter mode. The filter chooses one of three target sets: the listed CPUs, every active CPU except the writer, or the writer alone. One cycle after the write, the block raises a pending-set strobe for each chosen destination. The interrupt number comes out beside the strobes, so each destination's banked pending bitmap can set the matching bit.

Alongside the strobes, the block keeps a sender record for each destination and each interrupt number. This record is a mask with one bit per possible CPU. Each dispatch ORs the writer's bit into the record of every destination it reaches, and the bit stays set. Clearing these bits on acknowledge is left to the consumer. The register has no readable content. Every write, whether or not it reaches a target, produces a one-cycle update pulse, which tells downstream logic to recompute its pending summary.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, all pending-set strobes, the interrupt-number output and the update pulse are zero, and every sender-record bit is zero.
- R2: Filter mode 0 (word bits [25:24] = 0) targets the CPUs whose bits are set in word bits [23:16], where bit 16+i stands for CPU i. In the cycle after the write, the strobe of each target is high for exactly one cycle, and the interrupt-number output shows word bits [3:0].
- R3: In mode 0, an empty list (bits [23:16] all zero) raises no strobe and changes no sender record.
- R4: Filter mode 1 targets every active CPU except the writer, and ignores the list bits. With one active CPU, it targets nothing.
- R5: Filter mode 2 targets only the writing CPU, and ignores the list bits.
- R6: Filter mode 3 is reserved: it raises no strobe and changes no sender record.
- R7: No mode ever targets a CPU whose index is at or above the active-CPU count. This holds for list bits, for the all-others set and for a writer outside the active range.
- R8: For each target of a dispatch, the bit of the writing CPU is ORed into that target's sender record for the interrupt number. Bits set earlier stay set, and records of other destinations or other interrupt numbers do not change. Record of destination d, interrupt n, sender s is bit ((d*16+n)*8+s) of the record output.
- R9: The read-data output is always zero.
- R10: Every write raises the update pulse for exactly one cycle, in the cycle after the write, whatever targets it reaches.
- R11: Word bits [15:4] and [31:26] have no effect on targets, interrupt number or sender records.
- R12: Without a write, no strobe or update pulse is raised and the sender records hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the software-interrupt register |
| wr_data | input | 32 | Written word |
| wr_cpu | input | 3 | Index of the writing CPU |
| cpu_count | input | 4 | Number of active CPUs, 1 to 8 |
| rd_data | output | 32 | Register read value, always zero |
| pend_set | output | 8 | One-cycle pending-set strobe per destination CPU |
| pend_irq | output | 4 | Interrupt number accompanying the strobes |
| upd | output | 1 | One-cycle pulse after each write |
| src_mask | output | 1024 | Sender records, eight bits per destination and interrupt number |

## Verification
The hardest situation to reach is several dispatches from different writers landing on one destination and one interrupt number. Only that shows whether the record accumulates bits or overwrites them. The vector table routes two writes from different CPUs to the same destination and interrupt, and a running model of all records built from the expected targets is compared with the full record output after every vector. The active-count limit is reached by pairing reduced counts with list bits, with all-others sets and with a writer index above the count.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    // Field positions of the written word (decoded by sgi_decode)
    localparam int FLD_IRQ_LO  = 0;
    localparam int FLD_LIST_LO = 16;
    localparam int FLD_MODE_LO = 24;
    localparam int LIST_W      = 8;
    localparam int MODE_W      = 2;

    typedef enum logic [MODE_W-1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } filt_e;

endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
    import sgi_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic [31:0]       word,
    output logic [IRQ_W-1:0]  irq,
    output logic [LIST_W-1:0] list,
    output filt_e             mode
);

    always_comb begin
        irq  = word[FLD_IRQ_LO +: IRQ_W];
        list = word[FLD_LIST_LO +: LIST_W];
        mode = filt_e'(word[FLD_MODE_LO +: MODE_W]);
    end

endmodule

// File: rtl/sgi_target_filter.sv
module sgi_target_filter
    import sgi_pkg::*;
#(
    parameter int NCPU = 8,
    parameter int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1,
    parameter int CNTW = $clog2(NCPU + 1)
) (
    input  filt_e             mode,
    input  logic [LIST_W-1:0] list,
    input  logic [CPUW-1:0]   wr_cpu,
    input  logic [CNTW-1:0]   cpu_count,
    output logic [NCPU-1:0]   tgt
);

    logic [NCPU-1:0] active;
    logic [NCPU-1:0] self_oh;
    logic [NCPU-1:0] raw;

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        assign active[i]  = (CNTW'(i) < cpu_count);
        assign self_oh[i] = (wr_cpu == CPUW'(i));
    end

    always_comb begin
        unique case (mode)
            FLT_LIST:   raw = list[NCPU-1:0];
            FLT_OTHERS: raw = ~self_oh;
            FLT_SELF:   raw = self_oh;
            default:    raw = '0;
        endcase
        tgt = raw & active;
    end

endmodule

// File: rtl/sgi_src_bank.sv
module sgi_src_bank #(
    parameter int NCPU  = 8,
    parameter int NSGI  = 16,
    parameter int CPUW  = (NCPU > 1) ? $clog2(NCPU) : 1,
    parameter int IRQ_W = $clog2(NSGI),
    localparam int ROW_W = NSGI * NCPU
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCPU-1:0]        set_en,
    input  logic [IRQ_W-1:0]       irq,
    input  logic [CPUW-1:0]        sender,
    output logic [NCPU*ROW_W-1:0]  src_flat
);

    logic [NCPU-1:0] sender_oh;
    assign sender_oh = NCPU'(1) << sender;

    for (genvar d = 0; d < NCPU; d++) begin : g_dest
        logic [NSGI-1:0][NCPU-1:0] row_d, row_q;

        always_comb begin
            row_d = row_q;
            if (set_en[d]) begin
                row_d[irq] = row_q[irq] | sender_oh;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else begin
                row_q <= row_d;
            end
        end

        assign src_flat[d*ROW_W +: ROW_W] = row_q;
    end

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NCPU  = 8,
    parameter int NSGI  = 16,
    parameter int CPUW  = (NCPU > 1) ? $clog2(NCPU) : 1,
    parameter int CNTW  = $clog2(NCPU + 1),
    parameter int IRQ_W = $clog2(NSGI),
    localparam int SRC_W = NCPU * NSGI * NCPU
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [CPUW-1:0]   wr_cpu,
    input  logic [CNTW-1:0]   cpu_count,
    output logic [31:0]       rd_data,
    output logic [NCPU-1:0]   pend_set,
    output logic [IRQ_W-1:0]  pend_irq,
    output logic              upd,
    output logic [SRC_W-1:0]  src_mask
);

    typedef struct packed {
        logic [NCPU-1:0]  pend_set;
        logic [IRQ_W-1:0] pend_irq;
        logic             upd;
    } st_t;

    st_t st_d, st_q;

    logic [IRQ_W-1:0]  dec_irq;
    logic [LIST_W-1:0] dec_list;
    filt_e             dec_mode;
    logic [NCPU-1:0]   tgt;
    logic [NCPU-1:0]   set_en;

    sgi_decode #(.IRQ_W(IRQ_W)) u_decode (
        .word (wr_data),
        .irq  (dec_irq),
        .list (dec_list),
        .mode (dec_mode)
    );

    sgi_target_filter #(.NCPU(NCPU), .CPUW(CPUW), .CNTW(CNTW)) u_filter (
        .mode      (dec_mode),
        .list      (dec_list),
        .wr_cpu    (wr_cpu),
        .cpu_count (cpu_count),
        .tgt       (tgt)
    );

    assign set_en = wr_en ? tgt : '0;

    sgi_src_bank #(.NCPU(NCPU), .NSGI(NSGI), .CPUW(CPUW), .IRQ_W(IRQ_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .irq      (dec_irq),
        .sender   (wr_cpu),
        .src_flat (src_mask)
    );

    always_comb begin
        st_d          = '0;
        st_d.upd      = wr_en;
        st_d.pend_set = set_en;
        if (wr_en && (set_en != '0)) begin
            st_d.pend_irq = dec_irq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_set = st_q.pend_set;
    assign pend_irq = st_q.pend_irq;
    assign upd      = st_q.upd;
    assign rd_data  = '0;

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
    parameter int NCPU  = 8,
    parameter int NSGI  = 16,
    parameter int CPUW  = 3,
    parameter int CNTW  = 4,
    parameter int IRQ_W = 4,
    parameter int SRC_W = NCPU * NSGI * NCPU
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic [CPUW-1:0]   wr_cpu,
    input logic [CNTW-1:0]   cpu_count,
    input logic [31:0]       rd_data,
    input logic [NCPU-1:0]   pend_set,
    input logic [IRQ_W-1:0]  pend_irq,
    input logic              upd,
    input logic [SRC_W-1:0]  src_mask
);

    // R10
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> upd);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (pend_set == '0) && !upd);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(src_mask));

    // R9
    read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == 32'd0);

    // R6
    reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'd3) |=> (pend_set == '0) && $stable(src_mask));

    // R5
    self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'd2) |=> $onehot0(pend_set));

    // R4
    others_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'd1) |=> !pend_set[$past(wr_cpu)]);

    // R7
    active_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((pend_set >> $past(cpu_count)) == '0));

    // R2
    irq_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pend_set == '0) || (pend_irq == $past(wr_data[IRQ_W-1:0])));

endmodule

bind sgi_dispatch sgi_dispatch_chk #(
    .NCPU(NCPU), .NSGI(NSGI), .CPUW(CPUW), .CNTW(CNTW), .IRQ_W(IRQ_W),
    .SRC_W(NCPU * NSGI * NCPU)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_cpu(wr_cpu), .cpu_count(cpu_count), .rd_data(rd_data),
    .pend_set(pend_set), .pend_irq(pend_irq), .upd(upd), .src_mask(src_mask)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;

    localparam int NV = 12;

    // {word, writer(4), count(4), expected targets(8)}
    localparam logic [47:0] VEC [NV] = '{
        {32'h0005_0003, 4'd0, 4'd8, 8'h05},  // R2 list
        {32'h00F0_0007, 4'd1, 4'd4, 8'h00},  // R7 list above count
        {32'h0000_0009, 4'd2, 4'd8, 8'h00},  // R3 empty list
        {32'h0100_0001, 4'd2, 4'd8, 8'hFB},  // R4 all others
        {32'h01AA_000F, 4'd0, 4'd3, 8'h06},  // R4 R7 others, list ignored
        {32'h0201_0004, 4'd5, 4'd8, 8'h20},  // R5 self
        {32'h03FF_0002, 4'd1, 4'd8, 8'h00},  // R6 reserved
        {32'hFC81_FFF5, 4'd3, 4'd8, 8'h81},  // R11 junk bits
        {32'h0100_0006, 4'd0, 4'd1, 8'h00},  // R4 single CPU
        {32'h0004_0003, 4'd6, 4'd8, 8'h04},  // R8 accumulate cpu2 irq3
        {32'h0200_0000, 4'd7, 4'd8, 8'h80},  // R5 self top CPU
        {32'h0200_0008, 4'd3, 4'd2, 8'h00}   // R7 writer outside count
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   wr_cpu = '0;
    logic [3:0]   cpu_count = 4'd8;
    logic [31:0]  rd_data;
    logic [7:0]   pend_set;
    logic [3:0]   pend_irq;
    logic         upd;
    logic [1023:0] src_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_src [8][16];

    always #5 clk = ~clk;

    sgi_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_cpu(wr_cpu), .cpu_count(cpu_count), .rd_data(rd_data),
        .pend_set(pend_set), .pend_irq(pend_irq), .upd(upd), .src_mask(src_mask)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_src(input string req);
        int bad = 0;
        for (int d = 0; d < 8; d++)
            for (int n = 0; n < 16; n++)
                if (src_mask[(d*16+n)*8 +: 8] !== exp_src[d][n]) begin
                    if (bad == 0)
                        $display("FAIL %s record d%0d n%0d actual %0h expected %0h",
                                 req, d, n, src_mask[(d*16+n)*8 +: 8], exp_src[d][n]);
                    bad++;
                end
        checks++;
        if (bad != 0) errors++;
    endtask

    initial begin
        for (int d = 0; d < 8; d++)
            for (int n = 0; n < 16; n++)
                exp_src[d][n] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 strobes", {56'd0, pend_set}, 64'd0);
        check("R1 irq/upd", {59'd0, pend_irq, upd}, 64'd0);
        check_src("R1");
        check("R9 read", {32'd0, rd_data}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            logic [31:0] w;
            logic [7:0] e;
            w = VEC[v][47:16];
            e = VEC[v][7:0];
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = w;
            wr_cpu = VEC[v][14:12];
            cpu_count = VEC[v][11:8];
            @(negedge clk);
            wr_en = 1'b0;
            check($sformatf("R2 R4 R5 R6 R7 targets vec%0d", v), {56'd0, pend_set}, {56'd0, e});
            if (e != 0)
                check($sformatf("R2 irq vec%0d", v), {60'd0, pend_irq}, {60'd0, w[3:0]});
            check($sformatf("R10 upd vec%0d", v), {63'd0, upd}, 64'd1);
            for (int d = 0; d < 8; d++)
                if (e[d]) exp_src[d][w[3:0]] = exp_src[d][w[3:0]] | (8'd1 << VEC[v][14:12]);
            check_src($sformatf("R8 vec%0d", v));
            @(negedge clk);
            check($sformatf("R2 one-cycle vec%0d", v), {55'd0, pend_set, upd}, 64'd0);
        end

        // R8 accumulated record: cpu2 irq3 from senders 0 and 6
        check("R8 accumulate", {56'd0, src_mask[(2*16+3)*8 +: 8]}, 64'h41);

        // R12 idle with a live-looking word on the bus
        wr_data = 32'h0100_0005;
        wr_cpu = 3'd1;
        cpu_count = 4'd8;
        repeat (3) @(negedge clk);
        check("R12 idle", {55'd0, pend_set, upd}, 64'd0);
        check_src("R12 hold");
        check("R9 read end", {32'd0, rd_data}, 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule